// File: doc/BRIEF.md
# Multiplexed Nibble-Bus Cycle Sequencer

This block runs the bus side of a small CPU that shares one 4-bit bidirectional data bus for addresses, opcodes and operands. Each instruction takes eight clock cycles, called subcycles. They run in this fixed order: A1, A2, A3, M1, M2, X1, X2, X3. In every subcycle the block decides whether the CPU drives the bus or releases it, and what value it drives. It emits a sync pulse so that external memory can align to the cycle. It raises a ROM-select line while the last address nibble is on the bus.

The block holds a 12-bit instruction address. It sends the address out over the three A subcycles and advances it once per instruction. During the two M subcycles the bus is released, and the block latches the opcode nibbles that memory returns. In X1 it drives the operand nibble it has just latched. Decoding and execution of the instruction belong to other logic.

Every output is registered. The direction enable and the driven nibble are computed from the next subcycle and loaded at the same clock edge as the subcycle itself. Both therefore change only at subcycle boundaries.

Top module: `nibble_cycle_seq`

## Requirements
- R1: After reset the sequencer is in A1. It then steps one subcycle per clock in the order A1, A2, A3, M1, M2, X1, X2, X3 and wraps from X3 back to A1.
- R2: `busOe` is 1 in A1, A2, A3, X1 and X3. It is 0 in M1, M2 and X2.
- R3: The bus carries address bits 3:0 in A1, bits 7:4 in A2 and bits 11:8 in A3.
- R4: Reset sets the address to 0. The address increases by exactly 1 at each X3-to-A1 transition, and 12'hFFF wraps to 12'h000.
- R5: The bus value present in M1 is latched into `oprOut`, and the value present in M2 is latched into `opaOut`. Bus values in any other subcycle do not change either output.
- R6: In X1 the bus carries the nibble latched in M2 of the same instruction. In X3 the bus carries 4'h0.
- R7: `romSel` is 1 only in A3. It is a defined 0 in every other subcycle, including M2 and X2.
- R8: `syncOut` is 1 only in X3, once every eight clocks.
- R9: An active-low reset asserted at any point returns the block to A1 with address 0, `oprOut` and `opaOut` at 0, and `busOe` at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one subcycle per cycle |
| rstN | input | 1 | Asynchronous active-low reset |
| busIn | input | 4 | Value read from the shared bus |
| busOut | output | 4 | Nibble driven onto the bus when `busOe` is 1 |
| busOe | output | 1 | 1 = CPU drives the bus, 0 = bus released |
| syncOut | output | 1 | High during X3 |
| romSel | output | 1 | ROM-select line, high during A3 |
| oprOut | output | 4 | Opcode high nibble latched in M1 |
| opaOut | output | 4 | Opcode low nibble latched in M2 |

## Verification
Two pairs of functions share a single clock edge, and each pair is checked.

The first pair is the operand capture and the operand drive. The edge that ends M2 latches the operand nibble and also loads the X1 bus value. The bench returns a different operand in every instruction, including 4'h0 and 4'hF. It checks that X1 shows the new nibble and not the previous instruction's.

The second pair is the address increment and the first address nibble. The edge that ends X3 advances the address and also loads the A1 nibble. The bench checks that A1 already carries the incremented low nibble. This is checked across the carry from 12'h0FF and 12'hFFF and across the wrap to zero.

// File: rtl/seq_pkg.sv
package seq_pkg;

  typedef enum logic [2:0] {
    PH_A1 = 3'd0,
    PH_A2 = 3'd1,
    PH_A3 = 3'd2,
    PH_M1 = 3'd3,
    PH_M2 = 3'd4,
    PH_X1 = 3'd5,
    PH_X2 = 3'd6,
    PH_X3 = 3'd7
  } phase_e;

  localparam int ADDR_NIBS = 3;

  // Strobes from control to datapath
  typedef struct packed {
    logic [ADDR_NIBS-1:0] addrNibSel; // next subcycle drives address nibble i
    logic                 driveOpa;   // next subcycle drives operand
    logic                 capOpr;     // current subcycle latches high opcode nibble
    logic                 capOpa;     // current subcycle latches low opcode nibble
    logic                 incAddr;    // current subcycle ends the instruction
  } strobe_t;

  function automatic logic cpuDrives(phase_e ph);
    return (ph == PH_A1) || (ph == PH_A2) || (ph == PH_A3) ||
           (ph == PH_X1) || (ph == PH_X3);
  endfunction

endpackage

// File: rtl/seq_control.sv
module seq_control
  import seq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  output strobe_t strobes,
  output logic    busOe,
  output logic    syncOut,
  output logic    romSel
);

  phase_e phase;
  phase_e phaseNext;

  always_comb begin
    if (phase == PH_X3) phaseNext = PH_A1;
    else                phaseNext = phase_e'(phase + 3'd1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_A1;
      busOe   <= 1'b1;
      syncOut <= 1'b0;
      romSel  <= 1'b0;
    end else begin
      phase   <= phaseNext;
      busOe   <= cpuDrives(phaseNext);
      syncOut <= (phaseNext == PH_X3);
      romSel  <= (phaseNext == PH_A3);
    end
  end

  for (genvar i = 0; i < ADDR_NIBS; i++) begin : g_nibSel
    assign strobes.addrNibSel[i] = (phaseNext == phase_e'(PH_A1 + i));
  end
  assign strobes.driveOpa = (phaseNext == PH_X1);
  assign strobes.capOpr   = (phase == PH_M1);
  assign strobes.capOpa   = (phase == PH_M2);
  assign strobes.incAddr  = (phase == PH_X3);

  // R1: strict subcycle order
  a_r1_order: assert property (@(posedge clk) disable iff (!rstN)
    (phase != PH_X3) |=> (phase == phase_e'($past(phase) + 3'd1)));
  a_r1_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_X3) |=> (phase == PH_A1));
  // R2: bus released in M1, M2, X2
  a_r2_release: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_M1 || phase == PH_M2 || phase == PH_X2) |-> !busOe);
  // R7: ROM select is a defined zero in M2 and X2
  a_r7_romsel_low: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_M2 || phase == PH_X2) |-> (romSel === 1'b0));
  // R8: sync is a single-clock pulse
  a_r8_sync_pulse: assert property (@(posedge clk) disable iff (!rstN)
    syncOut |=> !syncOut);

endmodule

// File: rtl/seq_datapath.sv
module seq_datapath
  import seq_pkg::*;
#(
  parameter int NIB_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strobes,
  input  logic [NIB_W-1:0] busIn,
  output logic [NIB_W-1:0] busOut,
  output logic [NIB_W-1:0] oprOut,
  output logic [NIB_W-1:0] opaOut
);

  localparam int ADDR_W = ADDR_NIBS * NIB_W;

  logic [ADDR_W-1:0] addr;
  logic [ADDR_W-1:0] addrNext;
  logic [NIB_W-1:0]  addrNib [ADDR_NIBS];
  logic [NIB_W-1:0]  opaNext;
  logic [NIB_W-1:0]  busD;

  assign addrNext = strobes.incAddr ? addr + 1'b1 : addr;
  assign opaNext  = strobes.capOpa ? busIn : opaOut;

  for (genvar i = 0; i < ADDR_NIBS; i++) begin : g_nib
    assign addrNib[i] = addrNext[i*NIB_W +: NIB_W];
  end

  always_comb begin
    busD = '0;
    for (int i = 0; i < ADDR_NIBS; i++) begin
      if (strobes.addrNibSel[i]) busD = addrNib[i];
    end
    if (strobes.driveOpa) busD = opaNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addr   <= '0;
      busOut <= '0;
      oprOut <= '0;
      opaOut <= '0;
    end else begin
      addr   <= addrNext;
      busOut <= busD;
      opaOut <= opaNext;
      if (strobes.capOpr) oprOut <= busIn;
    end
  end

  // R4: one step per instruction, otherwise held
  a_r4_step: assert property (@(posedge clk) disable iff (!rstN)
    strobes.incAddr |=> (addr == $past(addr) + 1'b1));
  a_r4_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.incAddr |=> $stable(addr));
  // R5: opcode registers move only in their capture subcycle
  a_r5_opr_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.capOpr |=> $stable(oprOut));
  a_r5_opa_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.capOpa |=> $stable(opaOut));
  // R6: operand driven right after capture
  a_r6_x1_opa: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capOpa |=> (busOut == opaOut));

endmodule

// File: rtl/nibble_cycle_seq.sv
module nibble_cycle_seq
  import seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [3:0] busIn,
  output logic [3:0] busOut,
  output logic       busOe,
  output logic       syncOut,
  output logic       romSel,
  output logic [3:0] oprOut,
  output logic [3:0] opaOut
);

  strobe_t strobes;

  seq_control u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .busOe   (busOe),
    .syncOut (syncOut),
    .romSel  (romSel)
  );

  seq_datapath #(.NIB_W(4)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .busIn   (busIn),
    .busOut  (busOut),
    .oprOut  (oprOut),
    .opaOut  (opaOut)
  );

endmodule

// File: tb/nibble_cycle_seq_test.sv
module nibble_cycle_seq_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] busIn = 4'h0;
  logic [3:0] busOut, oprOut, opaOut;
  logic       busOe, syncOut, romSel;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [3:0] lastHi = 4'h0;
  logic [3:0] lastLo = 4'h0;

  always #5 clk = ~clk;

  nibble_cycle_seq uut (
    .clk(clk), .rstN(rstN), .busIn(busIn), .busOut(busOut), .busOe(busOe),
    .syncOut(syncOut), .romSel(romSel), .oprOut(oprOut), .opaOut(opaOut)
  );

  // {opr, opa} per instruction
  localparam logic [7:0] VEC [8] = '{8'h12, 8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h3C, 8'hF0, 8'h0F};

  task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // One instruction starting at A1, sampled at negedges
  task automatic runInstr(input logic [3:0] hi, input logic [3:0] lo, input logic [11:0] expAddr);
    for (int ph = 0; ph < 8; ph++) begin
      logic expOe;
      logic [3:0] expBus;
      expOe = (ph <= 2) || (ph == 5) || (ph == 7);
      chk("R2 busOe", {11'd0, busOe}, {11'd0, expOe});
      chk("R7 romSel", {11'd0, romSel}, {11'd0, ph == 2});
      chk("R8/R1 syncOut", {11'd0, syncOut}, {11'd0, ph == 7});
      if (expOe) begin
        case (ph)
          0: expBus = expAddr[3:0];
          1: expBus = expAddr[7:4];
          2: expBus = expAddr[11:8];
          5: expBus = lo;
          default: expBus = 4'h0;
        endcase
        if (ph <= 2) chk("R3/R4 address nibble", {8'd0, busOut}, {8'd0, expBus});
        else chk("R6 execute nibble", {8'd0, busOut}, {8'd0, expBus});
      end
      chk("R5 oprOut", {8'd0, oprOut}, {8'd0, (ph >= 4) ? hi : lastHi});
      chk("R5 opaOut", {8'd0, opaOut}, {8'd0, (ph >= 5) ? lo : lastLo});
      busIn = (ph == 3) ? hi : (ph == 4) ? lo : (4'h9 ^ 4'(ph) ^ hi);
      @(negedge clk);
    end
    lastHi = hi;
    lastLo = lo;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R9: state under reset
    repeat (2) @(negedge clk);
    chk("R9 reset busOe", {11'd0, busOe}, 12'd1);
    chk("R9 reset busOut", {8'd0, busOut}, 12'd0);
    chk("R9 reset sync", {11'd0, syncOut}, 12'd0);
    chk("R9 reset opr", {8'd0, oprOut}, 12'd0);
    rstN = 1'b1;

    // Table walk: R1..R8
    foreach (VEC[n]) runInstr(VEC[n][7:4], VEC[n][3:0], 12'(n));

    // R9: reset in the middle of an instruction
    for (int ph = 0; ph < 5; ph++) begin
      busIn = (ph == 3) ? 4'h7 : 4'h8;
      @(negedge clk);
    end
    rstN = 1'b0;
    @(negedge clk);
    chk("R9 mid reset opr", {8'd0, oprOut}, 12'd0);
    chk("R9 mid reset opa", {8'd0, opaOut}, 12'd0);
    chk("R9 mid reset busOe", {11'd0, busOe}, 12'd1);
    rstN = 1'b1;
    lastHi = 4'h0;
    lastLo = 4'h0;

    // R4: long run across 12'h0FF carry and 12'hFFF wrap
    for (int n = 0; n <= 4097; n++) runInstr(4'(n >> 4), 4'(n), 12'(n));

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule